// File: doc/BRIEF.md
# Digital Gain-Control Loop with Pulse-Density Output

This block closes a digital automatic gain loop around a pair of 6-bit in-phase and quadrature samples. For each accepted symbol it estimates the signal modulus without multipliers and subtracts a programmable reference level. It shifts the difference by a programmable power of two and adds the result into a 24-bit signed saturating integrator. The integrator has 8 integer bits and 16 fraction bits.

The integer byte of the integrator drives a first-order sigma-delta modulator. Its single-bit output has an average duty cycle that follows the byte. An external RC filter turns that bit into the gain-control voltage for an amplifier ahead of the converters. The integer byte can be read at any time. Writing it loads the byte and clears the fraction bits. Setting the coefficient to zero freezes the integrator, so the block becomes a programmable pulse-density voltage source.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is always high, and a sample is consumed on every clock edge where `in_valid` is high. Reference, coefficient, input format and invert settings are plain level inputs held by an external register bank.

Top module: `agc_loop`

## Requirements
- R1: `in_ready` is always 1. A sample is consumed only on a rising clock edge where `in_valid` is 1. Cycles with `in_valid` low leave the integrator unchanged.
- R2: With `cfg_signed`=1, samples are two's complement. With `cfg_signed`=0, they are offset binary: code 32 means zero and code 48 means +16. The modulus is max(|I|,|Q|) + floor(min(|I|,|Q|)/2), so I=8,Q=-12 gives 16 and I=Q=-32 gives 48.
- R3: For `coeff` G from 1 to 7, each consumed sample adds (modulus − `ref_level`)·2^(G−1) to the integrator. The integrator's LSB is 2^−16 of a step of the integer byte.
- R4: With G=0, the integrator holds its value whatever the input samples are.
- R5: A cycle with `int_wr`=1 loads `int_wdata` into the integer byte and clears all 16 fraction bits. A write takes priority over a sample update in the same cycle.
- R6: `int_rdata` is the integer byte as a signed value. A sample's effect shows there two clock edges after the edge that consumed it.
- R7: The integrator saturates at its most positive and most negative values and never wraps: +127 never changes to −128 in one step, and −128 never changes to +127.
- R8: With `invert`=0, an integer byte v gives exactly v+128 high cycles of `pdm_out` in any 256 consecutive cycles while v is steady. So −128 gives a constant 0, and +127 gives 255 high cycles out of 256.
- R9: With `invert`=1, the modulator uses the bitwise complement of v, so the count is 127−v per 256 cycles. `int_rdata` is unaffected by `invert`.
- R10: After reset, the integrator is 0 and `pdm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_i | input | 6 | In-phase sample |
| in_q | input | 6 | Quadrature sample |
| cfg_signed | input | 1 | 1 = two's complement, 0 = offset binary |
| ref_level | input | 6 | Unsigned target modulus |
| coeff | input | 3 | Loop gain exponent; 0 freezes the integrator |
| invert | input | 1 | Complements the level fed to the modulator |
| int_wr | input | 1 | Integer byte write strobe |
| int_wdata | input | 8 | Signed value to load |
| int_rdata | output | 8 | Signed integer byte of the integrator |
| pdm_out | output | 1 | Pulse-density gain-control bit |

## Verification
The properties assume that reset is asserted before use and that `in_valid`, `int_wr` and the settings are low or steady during reset. They also assume that `ref_level`, `coeff` and `invert` change only between bursts, not inside the two-cycle window that a hold or no-wrap check looks back over. The bench drives every input on the falling edge and holds `in_valid` and `int_wr` low during reset. It changes settings only while the stream is idle and the integrator has settled, so the properties' antecedents always see steady settings.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // Choice of multiplier-free modulus approximation.
  typedef enum logic {
    MOD_SUM_HALF = 1'b0,  // |I| + |Q|/2
    MOD_MAX_MIN  = 1'b1   // max + min/2
  } mod_kind_e;
endpackage

// File: rtl/agc_modulus.sv
module agc_modulus
  import agc_pkg::*;
#(
  parameter int        SW   = 6,
  parameter mod_kind_e KIND = MOD_MAX_MIN,
  localparam int       MW   = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          cfg_signed,
  input  logic [SW-1:0] in_i,
  input  logic [SW-1:0] in_q,
  output logic [MW-1:0] mod_q,
  output logic          mod_v
);
  logic [SW-1:0] si, sq;
  logic [MW-1:0] ei, eq, ai, aq, mod_d;

  // Offset binary becomes two's complement by flipping the top bit.
  always_comb begin
    si = cfg_signed ? in_i : {~in_i[SW-1], in_i[SW-2:0]};
    sq = cfg_signed ? in_q : {~in_q[SW-1], in_q[SW-2:0]};
    ei = {si[SW-1], si};
    eq = {sq[SW-1], sq};
    ai = ei[MW-1] ? (~ei + 1'b1) : ei;
    aq = eq[MW-1] ? (~eq + 1'b1) : eq;
  end

  generate
    if (KIND == MOD_MAX_MIN) begin : g_maxmin
      always_comb begin
        if (ai >= aq) mod_d = ai + (aq >> 1);
        else          mod_d = aq + (ai >> 1);
      end
    end else begin : g_sumhalf
      always_comb mod_d = ai + (aq >> 1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      mod_v <= 1'b0;
    end else begin
      mod_v <= in_valid;
      if (in_valid) mod_q <= mod_d;
    end
  end
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator #(
  parameter int  MW = 7,
  parameter int  RW = 6,
  parameter int  CW = 3,
  parameter int  IW = 8,
  parameter int  FW = 16,
  localparam int AW = IW + FW,
  localparam int EW = MW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mod_q,
  input  logic          mod_v,
  input  logic [RW-1:0] ref_level,
  input  logic [CW-1:0] coeff,
  input  logic          wr,
  input  logic [IW-1:0] wdata,
  output logic [IW-1:0] top
);
  localparam logic signed [AW:0] MAXV = {2'b00, {(AW-1){1'b1}}};
  localparam logic signed [AW:0] MINV = {2'b11, {(AW-1){1'b0}}};

  logic signed [AW-1:0] acc;
  logic signed [EW-1:0] err;
  logic signed [AW:0]   step, sum, sat;
  logic [CW-1:0]        sh;

  always_comb begin
    err  = $signed({1'b0, mod_q}) - $signed({{(EW-RW){1'b0}}, ref_level});
    sh   = coeff - 1'b1;
    step = $signed({{(AW+1-EW){err[EW-1]}}, err}) <<< sh;
    sum  = $signed({acc[AW-1], acc}) + step;
    if (sum > MAXV)      sat = MAXV;
    else if (sum < MINV) sat = MINV;
    else                 sat = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     acc <= '0;
    else if (wr)                    acc <= {wdata, {FW{1'b0}}};
    else if (mod_v && coeff != '0)  acc <= sat[AW-1:0];
  end

  assign top = acc[AW-1 -: IW];
endmodule

// File: rtl/agc_pdm.sv
module agc_pdm #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] level,
  input  logic          invert,
  output logic          pdm
);
  logic [IW-1:0] lv, u, acc, nxt;
  logic          carry;

  always_comb begin
    lv           = invert ? ~level : level;
    u            = {~lv[IW-1], lv[IW-2:0]};
    {carry, nxt} = {1'b0, acc} + {1'b0, u};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      pdm <= 1'b0;
    end else begin
      acc <= nxt;
      pdm <= carry;
    end
  end
endmodule

// File: rtl/agc_loop.sv
module agc_loop
  import agc_pkg::*;
#(
  parameter int        SW   = 6,
  parameter int        CW   = 3,
  parameter int        IW   = 8,
  parameter int        FW   = 16,
  parameter mod_kind_e KIND = MOD_MAX_MIN,
  localparam int       MW   = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_i,
  input  logic [SW-1:0] in_q,
  input  logic          cfg_signed,
  input  logic [SW-1:0] ref_level,
  input  logic [CW-1:0] coeff,
  input  logic          invert,
  input  logic          int_wr,
  input  logic [IW-1:0] int_wdata,
  output logic [IW-1:0] int_rdata,
  output logic          pdm_out
);
  logic [MW-1:0] mod_q;
  logic          mod_v;

  assign in_ready = 1'b1;

  agc_modulus #(.SW(SW), .KIND(KIND)) u_mod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_signed(cfg_signed),
    .in_i(in_i), .in_q(in_q), .mod_q(mod_q), .mod_v(mod_v)
  );

  agc_integrator #(.MW(MW), .RW(SW), .CW(CW), .IW(IW), .FW(FW)) u_int (
    .clk(clk), .rst_n(rst_n), .mod_q(mod_q), .mod_v(mod_v),
    .ref_level(ref_level), .coeff(coeff), .wr(int_wr), .wdata(int_wdata),
    .top(int_rdata)
  );

  agc_pdm #(.IW(IW)) u_pdm (
    .clk(clk), .rst_n(rst_n), .level(int_rdata), .invert(invert), .pdm(pdm_out)
  );
endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk #(
  parameter int IW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [CW-1:0] coeff,
  input logic          invert,
  input logic          int_wr,
  input logic [IW-1:0] int_wdata,
  input logic [IW-1:0] int_rdata,
  input logic          pdm_out
);
  localparam logic [IW-1:0] VMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] VMIN = {1'b1, {(IW-1){1'b0}}};

  // A write lands in the integer byte on the next edge.
  assert_write_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(int_wr) |-> int_rdata == $past(int_wdata));

  // No sample two edges back, or a zero gain: the byte holds.
  assert_hold_R1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(int_wr) && (!$past(in_valid, 2) || $past(coeff) == '0))
      |-> $stable(int_rdata));

  assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_rdata) == VMAX && !$past(int_wr)) |-> int_rdata != VMIN);

  assert_no_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_rdata) == VMIN && !$past(int_wr)) |-> int_rdata != VMAX);

  assert_pdm_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_rdata) == VMIN && !$past(invert)) |-> !pdm_out);

  assert_pdm_floor_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_rdata) == VMAX && $past(invert)) |-> !pdm_out);
endmodule

bind agc_loop agc_loop_chk #(.IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coeff(coeff),
  .invert(invert), .int_wr(int_wr), .int_wdata(int_wdata),
  .int_rdata(int_rdata), .pdm_out(pdm_out)
);

// File: tb/test_agc_loop.sv
module test_agc_loop;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_i = '0, in_q = '0;
  logic       cfg_signed = 1'b1;
  logic [5:0] ref_level = 6'd0;
  logic [2:0] coeff = 3'd0;
  logic       invert = 1'b0;
  logic       int_wr = 1'b0;
  logic [7:0] int_wdata = '0;
  logic [7:0] int_rdata;
  logic       pdm_out;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  agc_loop i_agc_loop (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .cfg_signed(cfg_signed), .ref_level(ref_level),
    .coeff(coeff), .invert(invert), .int_wr(int_wr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .pdm_out(pdm_out)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_int(logic [7:0] v);
    @(negedge clk); int_wr = 1'b1; int_wdata = v;
    @(negedge clk); int_wr = 1'b0;
  endtask

  task automatic send(logic [5:0] i, logic [5:0] q, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 1'b1; in_i = i; in_q = q;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_high(output int c);
    c = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); if (pdm_out) c++;
    end
  endtask

  task automatic t_reset;
    check("R10 rdata", int_rdata, 0);
    check("R10 pdm", pdm_out, 0);
    check("R1 ready", in_ready, 1);
  endtask

  task automatic t_write_clears;
    cfg_signed = 1'b1; ref_level = 6'd0; coeff = 3'd7;
    wr_int(8'h20);
    send(6'd16, 6'd0, 48);          // +0.75 of a byte step
    wr_int(8'h30);                  // must drop the fraction
    send(6'd16, 6'd0, 32);          // +0.5
    check("R5 fraction cleared", int_rdata, 8'h30);
    send(6'd16, 6'd0, 32);          // +0.5 -> exactly +1
    check("R3 err16 G7", int_rdata, 8'h31);
  endtask

  task automatic t_scaling;
    coeff = 3'd5; ref_level = 6'd0;
    wr_int(8'h10);
    send(6'h30, 6'd0, 256);         // -16 two's complement, 256 per sample
    check("R3 G5 negative input", int_rdata, 8'h11);
    coeff = 3'd7; ref_level = 6'd40;
    wr_int(8'h00);
    send(6'd16, 6'd0, 128);         // err -24 -> -3 steps
    check("R3 negative error", int_rdata, 8'hFD);
  endtask

  task automatic t_modulus;
    coeff = 3'd7; ref_level = 6'd0; cfg_signed = 1'b1;
    wr_int(8'h00);
    send(6'd8, 6'h34, 64);          // I=8,Q=-12 -> 16
    check("R2 max/min mix", int_rdata, 1);
    ref_level = 6'd32;
    wr_int(8'h00);
    send(6'h20, 6'h20, 64);         // -32,-32 -> 48, err 16
    check("R2 full scale", int_rdata, 1);
    cfg_signed = 1'b0; ref_level = 6'd0;
    wr_int(8'h00);
    send(6'd48, 6'd32, 64);         // offset +16, 0
    check("R2 offset binary", int_rdata, 1);
    cfg_signed = 1'b1;
  endtask

  task automatic t_valid_gate;
    coeff = 3'd7; ref_level = 6'd0;
    wr_int(8'h05);
    repeat (20) begin
      @(negedge clk); in_valid = 1'b0; in_i = 6'd31; in_q = 6'd31;
    end
    repeat (3) @(negedge clk);
    check("R1 idle ignored", int_rdata, 8'h05);
    check("R6 read back", int_rdata, 5);
  endtask

  task automatic t_hold_and_pdm;
    int c;
    coeff = 3'd0; invert = 1'b0;
    wr_int(8'h40);
    send(6'd31, 6'd31, 50);
    check("R4 zero gain hold", int_rdata, 8'h40);
    count_high(c); check("R8 duty 0x40", c, 192);
    invert = 1'b1;
    count_high(c); check("R9 inverted duty", c, 63);
    check("R9 rdata unchanged", int_rdata, 8'h40);
    invert = 1'b0;
    wr_int(8'h80);
    count_high(c); check("R8 duty floor", c, 0);
    wr_int(8'h7F);
    count_high(c); check("R8 duty top", c, 255);
  endtask

  task automatic t_saturate;
    coeff = 3'd7; ref_level = 6'd0;
    wr_int(8'h7F);
    send(6'd31, 6'd31, 100);
    check("R7 positive clamp", int_rdata, 8'h7F);
    ref_level = 6'd63;
    wr_int(8'h80);
    send(6'd0, 6'd0, 100);
    check("R7 negative clamp", int_rdata, 8'h80);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write_clears();
    t_scaling();
    t_modulus();
    t_valid_gate();
    t_hold_and_pdm();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule